// File: doc/BRIEF.md
# Zero-Address Stack Expression Evaluator

This unit runs a stream of zero-address instructions against an eight-entry operand stack and a sixteen-word data memory. Only the two transfer instructions name a memory word. A load copies that word onto the stack. A store writes the top entry back to that word and removes it from the stack. The two arithmetic instructions take no address. Each one removes the two most recent entries, computes a sum or a product, and places the result back on the stack. The instructions must already be in postfix order.

Instructions enter on a valid/ready stream. `in_ready` is high only while the unit is idle. An instruction transfers on a rising edge where both `in_valid` and `in_ready` are high, and `in_op` and `in_addr` are sampled at that edge. While an instruction executes, `busy` is high and `in_ready` is low. A producer that holds `in_valid` stays stalled until the unit returns to idle. A host port reads and writes the data memory. The host loads the operands before a program runs and collects the results after it finishes.

Top module: `zstk_eval`

## Requirements
- R1: Opcode 2'b00 (load) pushes the data word at the 4-bit `in_addr` onto the stack.
- R2: Opcode 2'b01 (store) writes the top entry to the data word at `in_addr` and removes that entry from the stack.
- R3: Opcode 2'b10 removes the top two entries and pushes their sum, truncated to 16 bits.
- R4: Opcode 2'b11 removes the top two entries and pushes the low 16 bits of their product.
- R5: Entries leave the stack in last-in first-out order. An arithmetic instruction uses only the two most recent entries, and deeper entries keep their values.
- R6: `in_ready` equals the inverse of `busy`. An accepted legal load or store keeps `busy` high for 1 cycle. An accepted legal arithmetic instruction keeps `busy` high for 3 cycles.
- R7: A store on an empty stack, or an arithmetic instruction with fewer than two entries, sets `err`. The instruction is dropped and leaves the stack and the memory unchanged, and `busy` stays low.
- R8: A load when 8 entries are held sets `err`. The instruction is dropped and the stack contents are unchanged.
- R9: Once set, `err` stays high until reset.
- R10: `host_rdata` shows the word at `host_addr` combinationally. A host write with `host_we` high takes effect at the clock edge. When a store writes the same word in the same cycle, the store wins.
- R11: Reset empties the stack, clears `err` and `busy`, raises `in_ready`, and zeroes all 16 data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_op | input | 2 | Opcode: 00 load, 01 store, 10 add, 11 multiply |
| in_addr | input | 4 | Data word address for load and store |
| busy | output | 1 | Instruction in progress |
| err | output | 1 | Sticky stack-misuse flag |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at host_addr |

## Verification
The bench sweeps operand pairs through both arithmetic paths. The pairs include the all-ones and high-bit values where carries and product bits past bit 15 must be dropped; a unit that keeps the wrong slice of the product or lets a carry in fails here. It fills the stack to its eight-entry limit, pushes one more, and then drains the stack. A wrong full test would either flag too early or overwrite an entry, and the drained order would then differ. It issues stores and sums with too few entries and reads back the memory and the surviving entry. A unit that executes those instructions anyway would corrupt a word or consume the lone entry. It also runs two complete postfix programs and times the busy window of each instruction class.

// File: rtl/zstk_pkg.sv
package zstk_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned MADDR_W = 4;
  localparam int unsigned STK_DEPTH = 8;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SUM   = 2'b10,
    OP_PROD  = 2'b11
  } zop_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_TAKE_A,
    ST_TAKE_B,
    ST_CALC
  } zstate_t;
endpackage

// File: rtl/zstk_stack.sv
module zstk_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  tos,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          has_two
);
  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx;

  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign has_two = (cnt_q >= CW'(2));
  assign top_idx = IW'(cnt_q - CW'(1));
  assign tos     = empty ? '0 : slot[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (push && !pop && !full) cnt_q <= cnt_q + CW'(1);
    else if (pop && !push && !empty) cnt_q <= cnt_q - CW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[i] <= '0;
      else if (push && !pop && cnt_q == CW'(i)) slot[i] <= wdata;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
  p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/zstk_dmem.sv
module zstk_dmem #(
  parameter int unsigned AW = 4,
  parameter int unsigned W  = 16,
  localparam int unsigned N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [W-1:0]  eng_wdata,
  output logic [W-1:0]  eng_rdata
);
  logic [W-1:0] word [N];

  assign host_rdata = word[host_addr];
  assign eng_rdata  = word[eng_addr];

  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) word[i] <= '0;
      else if (eng_we && eng_addr == AW'(i)) word[i] <= eng_wdata;
      else if (host_we && host_addr == AW'(i)) word[i] <= host_wdata;
    end
  end
endmodule

// File: rtl/zstk_alu.sv
module zstk_alu #(
  parameter int unsigned W = 16
) (
  input  logic         do_prod,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [2*W-1:0] prod_full;
  logic [W-1:0]   sum_tr;

  assign prod_full = a * b;
  assign sum_tr    = a + b;
  assign y         = do_prod ? prod_full[W-1:0] : sum_tr;
endmodule

// File: rtl/zstk_eval.sv
module zstk_eval
  import zstk_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned AW    = MADDR_W,
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_addr,
  output logic          busy,
  output logic          err,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata
);
  zstate_t       state_q, state_d;
  zop_t          op_q;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  opa_q, opb_q;
  logic          err_q;

  logic          stk_push, stk_pop;
  logic [W-1:0]  stk_wdata, stk_tos;
  logic [CW-1:0] stk_count;
  logic          stk_full, stk_empty, stk_two;
  logic          eng_we;
  logic [W-1:0]  eng_rdata, alu_y;
  logic          accept, refuse;
  zop_t          in_op_e;

  assign in_op_e  = zop_t'(in_op);
  assign busy     = (state_q != ST_IDLE);
  assign in_ready = !busy;
  assign err      = err_q;
  assign accept   = in_valid && in_ready;

  always_comb begin
    unique case (in_op_e)
      OP_LOAD:  refuse = stk_full;
      OP_STORE: refuse = stk_empty;
      default:  refuse = !stk_two;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_wdata = eng_rdata;
    eng_we    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !refuse)
          state_d = (in_op_e == OP_LOAD || in_op_e == OP_STORE) ? ST_XFER : ST_TAKE_A;
      end
      ST_XFER: begin
        if (op_q == OP_LOAD) stk_push = 1'b1;
        else begin
          stk_pop = 1'b1;
          eng_we  = 1'b1;
        end
        state_d = ST_IDLE;
      end
      ST_TAKE_A: begin
        stk_pop = 1'b1;
        state_d = ST_TAKE_B;
      end
      ST_TAKE_B: begin
        stk_pop = 1'b1;
        state_d = ST_CALC;
      end
      ST_CALC: begin
        stk_push  = 1'b1;
        stk_wdata = alu_y;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= in_op_e;
        addr_q <= in_addr;
        if (refuse) err_q <= 1'b1;
      end
      if (state_q == ST_TAKE_A) opa_q <= stk_tos;
      if (state_q == ST_TAKE_B) opb_q <= stk_tos;
    end
  end

  zstk_stack #(.DEPTH(DEPTH), .W(W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .wdata(stk_wdata), .tos(stk_tos), .count(stk_count),
    .full(stk_full), .empty(stk_empty), .has_two(stk_two)
  );

  zstk_dmem #(.AW(AW), .W(W)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .eng_we(eng_we), .eng_addr(addr_q), .eng_wdata(stk_tos),
    .eng_rdata(eng_rdata)
  );

  zstk_alu #(.W(W)) u_alu (
    .do_prod(op_q == OP_PROD), .a(opb_q), .b(opa_q), .y(alu_y)
  );

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !refuse) |=> busy);
  p_refuse_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && refuse) |=> (!busy && err_q && $stable(stk_count)));
  p_calc_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALC) |=> (stk_count == $past(stk_count) + CW'(1)));
  p_arith_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAKE_A) |=> (state_q == ST_TAKE_B));
endmodule

// File: tb/zstk_eval_tb.sv
module zstk_eval_tb;
  localparam logic [1:0] C_LOAD = 2'b00, C_STORE = 2'b01, C_SUM = 2'b10, C_PROD = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'b00;
  logic [3:0] in_addr = 4'h0;
  logic host_we = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic [15:0] host_wdata = 16'h0;
  logic in_ready, busy, err;
  logic [15:0] host_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  zstk_eval u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .busy(busy), .err(err),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hwr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic run(input logic [1:0] op, input logic [3:0] a, output int cyc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:8];
  endfunction

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] rd, a, b, c, d;
    int cyc;
    do_reset();
    // R11 reset state
    @(negedge clk);
    chk("R11 ready", in_ready, 1);
    chk("R11 busy", busy, 0);
    chk("R11 err", err, 0);
    hrd(4'd5, rd);
    chk("R11 mem zero", rd, 0);

    // R7 store on empty stack
    run(C_STORE, 4'd5, cyc);
    chk("R7 store-empty busy", cyc, 0);
    chk("R7 store-empty err", err, 1);
    hrd(4'd5, rd);
    chk("R7 mem untouched", rd, 0);

    // R11 reset clears err; R10 host write/read
    do_reset();
    chk("R11 err cleared", err, 0);
    hwr(4'd0, 16'h0007);
    hrd(4'd0, rd);
    chk("R10 host readback", rd, 16'h0007);
    // R1 load, R6 busy window
    run(C_LOAD, 4'd0, cyc);
    chk("R6 load busy cycles", cyc, 1);
    // R7 sum with one entry
    run(C_SUM, 4'd0, cyc);
    chk("R7 sum-underflow busy", cyc, 0);
    chk("R7 sum-underflow err", err, 1);
    run(C_STORE, 4'd9, cyc);
    chk("R6 store busy cycles", cyc, 1);
    hrd(4'd9, rd);
    chk("R7 lone entry kept R2", rd, 16'h0007);
    chk("R9 err sticky", err, 1);

    // R5/R8 fill, overflow, drain
    do_reset();
    for (int i = 0; i < 8; i++) hwr(4'(i), 16'h0100 + 16'(i));
    for (int i = 0; i < 8; i++) run(C_LOAD, 4'(i), cyc);
    chk("R8 no err at limit", err, 0);
    run(C_LOAD, 4'd0, cyc);
    chk("R8 overflow busy", cyc, 0);
    chk("R8 overflow err", err, 1);
    for (int i = 0; i < 8; i++) run(C_STORE, 4'(8 + i), cyc);
    for (int i = 0; i < 8; i++) begin
      hrd(4'(8 + i), rd);
      chk("R5 R8 drain order", rd, 16'h0107 - 16'(i));
    end

    // R5 deeper entry preserved
    do_reset();
    hwr(4'd0, 16'h0011); hwr(4'd1, 16'h0022); hwr(4'd2, 16'h0033);
    run(C_LOAD, 4'd0, cyc); run(C_LOAD, 4'd1, cyc); run(C_LOAD, 4'd2, cyc);
    run(C_SUM, 4'd0, cyc);
    chk("R6 arith busy cycles", cyc, 3);
    run(C_STORE, 4'd3, cyc); run(C_STORE, 4'd4, cyc);
    hrd(4'd3, rd); chk("R5 top pair sum", rd, 16'h0055);
    hrd(4'd4, rd); chk("R5 deeper entry", rd, 16'h0011);

    // R3/R4 sweep with corner values
    for (int k = 0; k < 64; k++) begin
      case (k)
        0: begin a = 16'hFFFF; b = 16'hFFFF; end
        1: begin a = 16'h8000; b = 16'h8000; end
        2: begin a = 16'h0000; b = 16'h1234; end
        3: begin a = 16'hFFFF; b = 16'h0001; end
        default: begin a = rnd(); b = rnd(); end
      endcase
      hwr(4'd0, a); hwr(4'd1, b);
      run(C_LOAD, 4'd0, cyc); run(C_LOAD, 4'd1, cyc); run(C_SUM, 4'd0, cyc);
      run(C_STORE, 4'd2, cyc);
      run(C_LOAD, 4'd0, cyc); run(C_LOAD, 4'd1, cyc); run(C_PROD, 4'd0, cyc);
      run(C_STORE, 4'd3, cyc);
      hrd(4'd2, rd); chk("R3 sum", rd, 16'((32'(a) + 32'(b)) & 32'hFFFF));
      hrd(4'd3, rd); chk("R4 product", rd, 16'((32'(a) * 32'(b)) & 32'hFFFF));
    end
    chk("R9 no err in legal sweep", err, 0);

    // (A+B)*(C+D)
    a = 16'd13; b = 16'd29; c = 16'd7; d = 16'd300;
    hwr(4'd4, a); hwr(4'd5, b); hwr(4'd6, c); hwr(4'd7, d);
    run(C_LOAD, 4'd4, cyc); run(C_LOAD, 4'd5, cyc); run(C_SUM, 4'd0, cyc);
    run(C_LOAD, 4'd6, cyc); run(C_LOAD, 4'd7, cyc); run(C_SUM, 4'd0, cyc);
    run(C_PROD, 4'd0, cyc); run(C_STORE, 4'd8, cyc);
    hrd(4'd8, rd);
    chk("R3 R4 expression X", rd, 16'(((32'(a) + 32'(b)) * (32'(c) + 32'(d))) & 32'hFFFF));

    // 3 4 * 5 6 * +  -> 42
    hwr(4'd0, 16'd3); hwr(4'd1, 16'd4); hwr(4'd2, 16'd5); hwr(4'd3, 16'd6);
    run(C_LOAD, 4'd0, cyc); run(C_LOAD, 4'd1, cyc); run(C_PROD, 4'd0, cyc);
    run(C_LOAD, 4'd2, cyc); run(C_LOAD, 4'd3, cyc); run(C_PROD, 4'd0, cyc);
    run(C_SUM, 4'd0, cyc); run(C_STORE, 4'd9, cyc);
    hrd(4'd9, rd);
    chk("R5 postfix 42", rd, 16'd42);
    chk("R6 idle ready", in_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule